// File: doc/BRIEF.md
# MSI Doorbell Vector Decoder

This block sits on the inbound memory-write path of a PCIe root port. Each incoming write request arrives as an address and a data word on a valid/ready stream. When the address equals the programmed 32-bit doorbell address, the write is treated as a message-signalled interrupt. Its data word is the vector number. It is offset by the port's vector base and becomes a one-cycle pulse on one line of a one-hot vector bus. Writes to any other address leave through a registered bypass stream with address and data unchanged.

Three configuration words are inputs. A control word carries the enable bit and the log2 of the vector count. A base word carries one 16-bit vector base per port, and the `PORT_SEL` parameter picks the half that this instance uses. The third word is the doorbell address. A doorbell write that arrives while decoding is disabled raises the MSI error event. A vector number outside the programmed range raises the bad-data event. Neither case fires a vector.

Stream rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while the bypass register holds a beat that the consumer has not taken (`byp_valid` high, `byp_ready` low). This applies to doorbell writes as well, so requests stay in order. A bypass beat stays stable until `byp_ready` takes it.

Top module: `msidb_decoder`

## Requirements
- R1: After reset, `vec_pulse`, `err_msi`, `err_bad_data` and `byp_valid` are all zero and `req_ready` is high.
- R2: An accepted write whose address equals `cfg_doorbell` produces a pulse on bit (base + data) of `vec_pulse` in the cycle after acceptance. This needs three conditions: enable (control word bit 0) is 1, data is below 2^L (L is control word bits [8:4]), and base + data is below `NUM_VEC`. Exactly one bit is set.
- R3: Each accepted doorbell write produces at most one cycle of vector pulse. No vector bit is high unless a request was accepted on the previous edge.
- R4: An enabled doorbell write with data >= 2^L pulses `err_bad_data` for one cycle and fires no vector.
- R5: An enabled doorbell write with data < 2^L but base + data >= `NUM_VEC` pulses `err_bad_data` and fires no vector.
- R6: A doorbell write while the enable bit is 0 pulses `err_msi` for one cycle, fires no vector and does not raise `err_bad_data`.
- R7: A write to any other address appears on the bypass stream the cycle after acceptance, with the same address and data. It raises no vector or error, whatever the enable bit holds.
- R8: With `PORT_SEL`=0 the base is base word bits [15:0]. With `PORT_SEL`=1 it is bits [31:16]. The other half has no effect.
- R9: While `byp_valid` is high and `byp_ready` is low, `req_ready` is low and the bypass address and data hold steady. A doorbell write presented during the stall is not decoded until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 32 | Control word: bit 0 enable, bits [8:4] log2 vector count |
| cfg_base | input | 32 | Vector bases: port 0 in [15:0], port 1 in [31:16] |
| cfg_doorbell | input | 32 | Doorbell address |
| req_valid | input | 1 | Inbound write request valid |
| req_ready | output | 1 | Inbound write request ready |
| req_addr | input | 32 | Write address |
| req_data | input | 32 | Write data |
| vec_pulse | output | NUM_VEC | One-hot vector pulse |
| err_msi | output | 1 | Doorbell write while disabled |
| err_bad_data | output | 1 | Vector number out of range |
| byp_valid | output | 1 | Bypass beat valid |
| byp_ready | input | 1 | Bypass beat taken |
| byp_addr | output | 32 | Bypass address |
| byp_data | output | 32 | Bypass data |

## Verification
The assertions check on every cycle the properties that can be stated without a reference model. The vector bus is never more than one-hot. A vector bit never rises without an acceptance on the previous edge. A vector never coincides with an error. A disabled-write error never coincides with bad data. A stalled bypass beat holds steady while ready is low. Only the bench's scenarios can show that the right vector index fires for a given base and data, where the range limits fall for each log2 value, which base half is used, and that a doorbell write waiting through a stall fires exactly once after the stall clears.

// File: rtl/msidb_pkg.sv
package msidb_pkg;
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_L2_LSB = 4;
  localparam int unsigned CTRL_L2_W   = 5;
  localparam int unsigned PORT_BASE_W = 16;

  typedef enum logic [1:0] {
    CLS_PASS = 2'd0,
    CLS_FIRE = 2'd1,
    CLS_BAD  = 2'd2,
    CLS_OFF  = 2'd3
  } msidb_cls_e;

  typedef struct packed {
    logic                   enable;
    logic [CTRL_L2_W-1:0]   log2_num;
    logic [PORT_BASE_W-1:0] base;
  } msidb_cfg_t;
endpackage

// File: rtl/msidb_cfg_decode.sv
module msidb_cfg_decode
  import msidb_pkg::*;
#(
  parameter int unsigned PORT_SEL = 0
) (
  input  logic [31:0] ctrl_word,
  input  logic [31:0] base_word,
  output msidb_cfg_t  cfg
);
  localparam int unsigned BASE_LSB = PORT_SEL * PORT_BASE_W;

  always_comb begin
    cfg.enable   = ctrl_word[CTRL_EN_BIT];
    cfg.log2_num = ctrl_word[CTRL_L2_LSB +: CTRL_L2_W];
    cfg.base     = base_word[BASE_LSB +: PORT_BASE_W];
  end
endmodule

// File: rtl/msidb_classify.sv
module msidb_classify
  import msidb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int unsigned SUM_W  = ((DATA_W > PORT_BASE_W) ? DATA_W : PORT_BASE_W) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] doorbell,
  input  msidb_cfg_t        cfg,
  output msidb_cls_e        cls,
  output logic [VIDX_W-1:0] vec_idx
);
  logic             hit;
  logic             over_l2;
  logic             over_bus;
  logic [SUM_W-1:0] sum;

  always_comb begin
    hit      = (addr == doorbell);
    over_l2  = ((data >> cfg.log2_num) != '0);
    sum      = SUM_W'(data) + SUM_W'(cfg.base);
    over_bus = (sum >= SUM_W'(NUM_VEC));
    vec_idx  = sum[VIDX_W-1:0];
    if (!hit)                     cls = CLS_PASS;
    else if (!cfg.enable)         cls = CLS_OFF;
    else if (over_l2 || over_bus) cls = CLS_BAD;
    else                          cls = CLS_FIRE;
  end
endmodule

// File: rtl/msidb_pulse_gen.sv
module msidb_pulse_gen #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [VIDX_W-1:0]  idx,
  output logic [NUM_VEC-1:0] pulse
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= fire && (idx == VIDX_W'(g));
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse));
endmodule

// File: rtl/msidb_bypass_reg.sv
module msidb_bypass_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (free) begin
      out_valid <= load;
      if (load) begin
        out_addr <= in_addr;
        out_data <= in_data;
      end
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
endmodule

// File: rtl/msidb_decoder.sv
module msidb_decoder
  import msidb_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 32,
  parameter int unsigned PORT_SEL = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cfg_ctrl,
  input  logic [31:0]        cfg_base,
  input  logic [31:0]        cfg_doorbell,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_data,
  output logic [NUM_VEC-1:0] vec_pulse,
  output logic               err_msi,
  output logic               err_bad_data,
  output logic               byp_valid,
  input  logic               byp_ready,
  output logic [31:0]        byp_addr,
  output logic [31:0]        byp_data
);
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  msidb_cfg_t        cfg;
  msidb_cls_e        cls;
  logic [VIDX_W-1:0] idx;
  logic              accept;
  logic              free;

  msidb_cfg_decode #(.PORT_SEL(PORT_SEL)) u_cfg (
    .ctrl_word (cfg_ctrl),
    .base_word (cfg_base),
    .cfg       (cfg)
  );

  msidb_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_cls (
    .addr     (req_addr),
    .data     (req_data),
    .doorbell (cfg_doorbell),
    .cfg      (cfg),
    .cls      (cls),
    .vec_idx  (idx)
  );

  assign req_ready = free;
  assign accept    = req_valid && free;

  msidb_pulse_gen #(.NUM_VEC(NUM_VEC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (accept && (cls == CLS_FIRE)),
    .idx   (idx),
    .pulse (vec_pulse)
  );

  msidb_bypass_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_byp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && (cls == CLS_PASS)),
    .in_addr   (req_addr),
    .in_data   (req_data),
    .free      (free),
    .out_valid (byp_valid),
    .out_ready (byp_ready),
    .out_addr  (byp_addr),
    .out_data  (byp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_msi      <= 1'b0;
      err_bad_data <= 1'b0;
    end else begin
      err_msi      <= accept && (cls == CLS_OFF);
      err_bad_data <= accept && (cls == CLS_BAD);
    end
  end

  assert_pulse_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_pulse != '0) |-> $past(req_valid && req_ready));
  assert_no_vec_with_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_data |-> (vec_pulse == '0));
  assert_off_is_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_msi |-> (!err_bad_data && (vec_pulse == '0)));
  assert_ready_low_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && !byp_ready) |-> !req_ready);
endmodule

// File: tb/msidb_decoder_tb.sv
module msidb_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;
  localparam logic [31:0] DB = 32'hFFFF_F000;

  typedef struct packed {
    logic        en;
    logic [4:0]  l2;
    logic [15:0] base;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  kind;   // 0 vector, 1 bad data, 2 disabled error, 3 bypass
    logic [4:0]  idx;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 5'd3, 16'd0,  DB,            32'd5,  2'd0, 5'd5},
    '{1'b1, 5'd3, 16'd0,  DB,            32'd8,  2'd1, 5'd0},
    '{1'b1, 5'd3, 16'd0,  DB,            32'd7,  2'd0, 5'd7},
    '{1'b1, 5'd4, 16'd20, DB,            32'd11, 2'd0, 5'd31},
    '{1'b1, 5'd4, 16'd20, DB,            32'd12, 2'd1, 5'd0},
    '{1'b0, 5'd3, 16'd0,  DB,            32'd1,  2'd2, 5'd0},
    '{1'b1, 5'd3, 16'd0,  32'hFFFF_F004, 32'd3,  2'd3, 5'd0},
    '{1'b1, 5'd0, 16'd9,  DB,            32'd0,  2'd0, 5'd9},
    '{1'b1, 5'd0, 16'd9,  DB,            32'd1,  2'd1, 5'd0},
    '{1'b0, 5'd3, 16'd0,  32'h0000_1000, 32'hABCD, 2'd3, 5'd0},
    '{1'b1, 5'd5, 16'd0,  DB,            32'd31, 2'd0, 5'd31}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_ctrl = 0, cfg_base = 0, cfg_doorbell = DB;
  logic req_valid = 0, byp_ready = 1;
  logic [31:0] req_addr = 0, req_data = 0;
  logic req_ready, err_msi, err_bad_data, byp_valid;
  logic [NV-1:0] vec_pulse;
  logic [31:0] byp_addr, byp_data;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msidb_decoder #(.NUM_VEC(NV), .PORT_SEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
    .cfg_doorbell(cfg_doorbell), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .vec_pulse(vec_pulse),
    .err_msi(err_msi), .err_bad_data(err_bad_data), .byp_valid(byp_valid),
    .byp_ready(byp_ready), .byp_addr(byp_addr), .byp_data(byp_data));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic set_cfg(input logic en, input logic [4:0] l2, input logic [15:0] b);
    cfg_ctrl = '0;
    cfg_ctrl[0] = en;
    cfg_ctrl[8:4] = l2;
    cfg_ctrl[31:28] = 4'hF;            // unused bits, must not matter
    cfg_base = {16'h000A, b};          // R8: upper half belongs to the other port
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is still applied and just after release
    chk("R1", "vec_pulse", 64'(vec_pulse), 64'd0);
    chk("R1", "errors", {62'd0, err_msi, err_bad_data}, 64'd0);
    chk("R1", "byp_valid", 64'(byp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      string rq;
      logic [NV-1:0] ev;
      set_cfg(TBL[i].en, TBL[i].l2, TBL[i].base);
      req_addr = TBL[i].addr; req_data = TBL[i].data; req_valid = 1;
      @(posedge clk); #1;
      req_valid = 0;
      case (TBL[i].kind)
        2'd0: rq = "R2";
        2'd1: rq = ((TBL[i].data >> TBL[i].l2) != 0) ? "R4" : "R5";
        2'd2: rq = "R6";
        default: rq = "R7";
      endcase
      ev = (TBL[i].kind == 2'd0) ? (NV'(1) << TBL[i].idx) : '0;
      chk(rq, $sformatf("row %0d vec_pulse", i), 64'(vec_pulse), 64'(ev));
      chk(rq, $sformatf("row %0d err_bad_data", i), 64'(err_bad_data), 64'(TBL[i].kind == 2'd1));
      chk(rq, $sformatf("row %0d err_msi", i), 64'(err_msi), 64'(TBL[i].kind == 2'd2));
      chk(rq, $sformatf("row %0d byp_valid", i), 64'(byp_valid), 64'(TBL[i].kind == 2'd3));
      if (TBL[i].kind == 2'd3)
        chk("R7", $sformatf("row %0d bypass beat", i), {byp_addr, byp_data},
            {TBL[i].addr, TBL[i].data});
      @(posedge clk); #1;
      // R3: pulses last one cycle only
      chk("R3", $sformatf("row %0d pulse gone", i),
          {vec_pulse, err_msi, err_bad_data}, 64'd0);
      @(negedge clk);
    end

    // R8: vector index uses only the low half of the base word
    set_cfg(1'b1, 5'd2, 16'd3);
    req_addr = DB; req_data = 32'd2; req_valid = 1;
    @(posedge clk); #1; req_valid = 0;
    chk("R8", "low-half base", 64'(vec_pulse), 64'(NV'(1) << 5));
    @(negedge clk);

    // R9: stall on bypass back-pressure
    byp_ready = 0;
    req_addr = 32'h0000_2000; req_data = 32'h55; req_valid = 1;
    @(posedge clk); #1;
    chk("R9", "stalled beat valid", 64'(byp_valid), 64'd1);
    chk("R9", "ready low in stall", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_addr = DB; req_data = 32'd1;   // doorbell waits behind the stall
    repeat (2) @(posedge clk);
    #1;
    chk("R9", "no pulse while not accepted", 64'(vec_pulse), 64'd0);
    chk("R9", "beat held", {byp_addr, byp_data}, {32'h0000_2000, 32'h55});
    @(negedge clk);
    byp_ready = 1;
    @(posedge clk); #1; req_valid = 0;
    chk("R9", "doorbell fires after stall", 64'(vec_pulse), 64'(NV'(1) << 4));
    chk("R9", "bypass drained", 64'(byp_valid), 64'd0);
    @(posedge clk); #1;
    chk("R3", "single pulse after stall", 64'(vec_pulse), 64'd0);

    finish_run();
  end
endmodule